// File: doc/BRIEF.md
# I2C Control-Register Target with Write-Then-Read-Back

This block is an I2C target that lets an external bus master reach a small bank of 8-bit control registers. It does not clock anything from SCL. Instead it samples SCL and SDA with the system clock through short synchronizer chains, then looks for bus edges and conditions in the sampled stream. The system clock must therefore be running for any access. The block answers one fixed 7-bit device address. It drives SDA as an open-drain, active-low pull request, and the pad and an external pull-up complete the line.

After the address byte with the direction bit cleared, the master sends a command byte. This byte selects a register and chooses between two flows:

- **Plain flow.** Either one data byte follows and is stored, or the master issues a repeated START and the addressed register is read back.
- **Read-back flow.** The target first stores the data byte. It then shifts out the stored value straight away in the same transfer, with no second address phase.

The register contents are also presented in parallel for use inside the chip.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset all registers read 0x00, `regs_o` is all zero and `sda_pull_o` is low (SDA released).
- R2: The device address is binary 0011010. The target ACKs an address byte by pulling SDA low during the ninth SCL clock only when its upper seven bits match. On a mismatch it does not ACK, and it ACKs nothing more and changes no register until the next START.
- R3: In the command byte, bit 7 is the read-back flag and bits 2..0 are the register index. Bits 6..3 have no effect.
- R4: START, address with R/W=0, command with flag 0, one data byte, STOP stores the data byte in the indexed register. Register i appears on `regs_o[8*i+7:8*i]` and no other register changes.
- R5: START, address with R/W=0, command with flag 0, repeated START, address with R/W=1 makes the target send the indexed register MSB first, one bit per SCL clock.
- R6: With the read-back flag set, the target ACKs the data byte, stores it, and then sends the stored value MSB first over the next eight SCL clocks.
- R7: The target changes its SDA drive only while SCL is low.
- R8: A STOP or START that arrives before the eighth bit of a data byte aborts that byte, and no register is updated.
- R9: After a byte sent by the target, a master ACK makes the target send the same register again. A master NACK makes it release SDA until the next START.
- R10: A write transfer carries one data byte. A further data byte is not ACKed and does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 64 | All registers, register i in bits 8*i+7..8*i |

## Verification
The bench builds the block with its defaults: device address 0011010, eight registers and two synchronizer stages. With eight registers, every value of the 3-bit index field is a live register, so a write that lands on the wrong index shows up when all eight registers are compared. The command bytes set the ignored middle bits to nonzero patterns. The bus quarter-period is eight system clocks, which leaves room for the synchronizer latency before each SCL edge and keeps the transfers short.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/line_sync.sv
`timescale 1ns/1ps
module line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bus_cond_det.sv
`timescale 1ns/1ps
module bus_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edges only count while SCL stayed high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned W        = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      widx_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [IDX_W-1:0]      ridx_i,
  output logic [W-1:0]          rdata_o,
  output logic [NUM_REGS*W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && widx_i == IDX_W'(g))        q <= wdata_i;
    end
    assign regs_o[g*W +: W] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = regs_o[i*W +: W];
    end
  end

  assert_hold_unless_written_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !we_i |=> $stable(regs_o));
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0011010,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  bus_cond_det u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c));

  tgt_state_e          state_q;
  logic [3:0]          cnt_q;
  logic [BYTE_W-1:0]   sh_q, tx_q;
  logic [IDX_W-1:0]    idx_q;
  logic                rw_q, rb_q, mack_q, drive_q;
  logic [BYTE_W-1:0]   rdata;
  logic                byte_done, wr_en, addr_hit;

  assign byte_done = scl_fall && (cnt_q == 4'd8);
  assign wr_en     = (state_q == ST_WDATA) && byte_done;
  assign addr_hit  = (sh_q[7:1] == DEV_ADDR);

  reg_bank #(.NUM_REGS(NUM_REGS), .W(BYTE_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .widx_i(idx_q),
    .wdata_i(sh_q), .ridx_i(idx_q), .rdata_o(rdata), .regs_o(regs_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      idx_q   <= '0;
      rw_q    <= 1'b0;
      rb_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
    end else if (start_c) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else if (stop_c) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                rw_q    <= sh_q[0];
                drive_q <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              rb_q    <= sh_q[7];
              idx_q   <= sh_q[IDX_W-1:0];
              drive_q <= 1'b1;
              state_q <= ST_CMD_ACK;
            end else begin
              drive_q <= 1'b1;
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= {rdata[BYTE_W-2:0], 1'b1};
            drive_q <= ~rdata[BYTE_W-1];
            state_q <= ST_TX;
          end else begin
            drive_q <= 1'b0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD_ACK: if (scl_fall) begin
          cnt_q   <= '0;
          drive_q <= 1'b0;
          state_q <= ST_WDATA;
        end
        ST_WDATA_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rb_q) begin
            // register already holds the new byte
            tx_q    <= {rdata[BYTE_W-2:0], 1'b1};
            drive_q <= ~rdata[BYTE_W-1];
            state_q <= ST_TX;
          end else begin
            drive_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 4'd1;
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              drive_q <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              drive_q <= ~tx_q[BYTE_W-1];
              tx_q    <= {tx_q[BYTE_W-2:0], 1'b1};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            cnt_q <= '0;
            if (mack_q) begin
              tx_q    <= {rdata[BYTE_W-2:0], 1'b1};
              drive_q <= ~rdata[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = drive_q;

  assert_drive_scl_low_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (drive_q != $past(drive_q)) |-> !$past(scl_s));

  assert_ack_only_match_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> ($past(sh_q[7:1]) == DEV_ADDR));

  assert_start_restarts_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    start_c |=> (state_q == ST_ADDR && cnt_q == 4'd0));

  assert_stop_releases_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> (state_q == ST_IDLE && !drive_q));

  assert_nack_releases_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_TX_ACK) |-> !drive_q);
endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic        sda_bus;
  logic [63:0] regs;
  logic [7:0]  model [8];
  int          n_chk = 0;
  int          n_bad = 0;
  int          r7_viol = 0;
  logic        pull_prev = 1'b0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_reg_target u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .regs_o(regs));

  always @(negedge clk) begin
    if (rst_ni && sda_pull != pull_prev && scl_m) r7_viol++;
    pull_prev = sda_pull;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_bus;
      wq();
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic check_all_regs(input string tag);
    for (int i = 0; i < 8; i++)
      chk(regs[i*8 +: 8] == model[i], tag, int'(regs[i*8 +: 8]), int'(model[i]));
  endtask

  // R4: plain write
  task automatic t_write(input int idx, input logic [7:0] v);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h34, a0);
    send_byte({5'b01010, 3'(idx)}, a1);   // R3: bits 6..3 nonzero, ignored
    send_byte(v, a2);
    bus_stop();
    chk(a0 && a1 && a2, "R2 write acks", {a0, a1, a2}, 3'b111);
    model[idx] = v;
    chk(regs[idx*8 +: 8] == v, "R4 write lands", int'(regs[idx*8 +: 8]), int'(v));
  endtask

  // R5: indexed read via repeated START
  task automatic t_read(input int idx, input logic mack_twice);
    logic a0, a1, a2;
    logic [7:0] b;
    bus_start();
    send_byte(8'h34, a0);
    send_byte({5'b00000, 3'(idx)}, a1);
    bus_rstart();
    send_byte(8'h35, a2);
    chk(a0 && a1 && a2, "R5 read acks", {a0, a1, a2}, 3'b111);
    if (mack_twice) begin
      recv_byte(b, 1'b1);
      chk(b == model[idx], "R9 first byte", int'(b), int'(model[idx]));
      recv_byte(b, 1'b1);
      chk(b == model[idx], "R9 repeated byte", int'(b), int'(model[idx]));
    end
    recv_byte(b, 1'b0);
    chk(b == model[idx], "R5 read data", int'(b), int'(model[idx]));
    chk(sda_pull == 1'b0, "R9 released after NACK", int'(sda_pull), 0);
    bus_stop();
  endtask

  // R6: write then read-back in one transfer
  task automatic t_readback(input int idx, input logic [7:0] v, input logic [3:0] junk);
    logic a0, a1, a2;
    logic [7:0] b;
    bus_start();
    send_byte(8'h34, a0);
    send_byte({1'b1, junk, 3'(idx)}, a1);
    send_byte(v, a2);
    recv_byte(b, 1'b0);
    bus_stop();
    model[idx] = v;
    chk(a0 && a1 && a2, "R6 acks", {a0, a1, a2}, 3'b111);
    chk(b == v, "R6 read-back value", int'(b), int'(v));
    check_all_regs("R3 index only");
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h36, a0);
    send_byte(8'h01, a1);
    send_byte(8'hEE, a2);
    bus_stop();
    chk(!a0, "R2 mismatch no ack", int'(a0), 0);
    chk(!a1 && !a2, "R2 idle after mismatch", {a1, a2}, 0);
    check_all_regs("R2 regs unchanged");
  endtask

  task automatic t_abort();
    logic a0, a1, a2;
    logic [7:0] b;
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h05, a1);
    send_bits(8'hA5, 4);
    bus_stop();
    check_all_regs("R8 stop abort");
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h06, a1);
    send_bits(8'h3C, 7);
    bus_rstart();
    send_byte(8'h35, a2);
    recv_byte(b, 1'b0);
    bus_stop();
    chk(b == model[6], "R8 restart abort read", int'(b), int'(model[6]));
    check_all_regs("R8 restart abort");
  endtask

  task automatic t_extra_byte();
    logic a0, a1, a2, a3;
    bus_start();
    send_byte(8'h34, a0);
    send_byte(8'h02, a1);
    send_byte(8'h9D, a2);
    send_byte(8'h42, a3);
    bus_stop();
    model[2] = 8'h9D;
    chk(a2 && !a3, "R10 second byte nack", {a2, a3}, 2'b10);
    check_all_regs("R10 first byte kept");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(regs == 64'h0, "R1 regs reset", int'(regs[31:0]), 0);
    chk(sda_pull == 1'b0, "R1 sda released", int'(sda_pull), 0);
    t_read(3, 1'b0);
    for (int i = 0; i < 8; i++) t_write(i, 8'(8'h5A ^ (i * 8'h1D)));
    check_all_regs("R4 all regs");
    for (int i = 0; i < 8; i++) t_read(i, 1'b0);
    t_readback(4, 8'hC3, 4'b1111);
    t_readback(1, 8'h80, 4'b0110);
    t_readback(7, 8'h01, 4'b1001);
    t_read(4, 1'b1);
    t_bad_addr();
    t_abort();
    t_extra_byte();
    t_read(2, 1'b0);
    chk(r7_viol == 0, "R7 drive changes only with SCL low", r7_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule